// File: doc/BRIEF.md
# Sequential 3x3 Cholesky Factoriser

The block factors a symmetric positive-definite 3x3 matrix A into a lower-triangular L with A = L·Lᵀ. All values are unsigned integers. One restoring divider, one Newton square-root sequencer and one multiplier are shared under a small scheduler. The scheduler walks the lower triangle row by row. For each entry it first accumulates the dot product of the entries already known, then issues either a square root (diagonal) or a divide (below the diagonal).

A caller places the matrix on the packed input word and pulses start for one cycle. Some hundreds of cycles later, done pulses for one cycle. From then on the packed output word holds L, and err tells whether a diagonal radicand was not positive. The result stays on the output until the next accepted start.

Top module: `chol3_engine`

## Requirements
- R1: Asserting the asynchronous active-low reset, at any time, forces the L word to all zeros and done and err to 0.
- R2: Element (r,c) of A is read from input bits [16·(3r+c)+15 : 16·(3r+c)] as an unsigned 16-bit value and zero-extended to 24 bits. Only slots with c ≤ r are read. The three upper slots have no effect on any output.
- R3: The output word carries nine 24-bit entries in row-major order. Entry (r,c) is at bits [24·(8−(3r+c))+23 : 24·(8−(3r+c))], so L00 is the top 24 bits. The upper entries (0,1), (0,2) and (1,2) are always zero.
- R4: A diagonal entry L[i][i] is the result of three Newton steps x ← ⌊(x + ⌊t/x⌋)/2⌋ on t = A[i][i] − Σ_{k<i} L[i][k]². The steps start from x = 255, and every division is an integer floor.
- R5: An entry below the diagonal is L[i][j] = ⌊n / L[j][j]⌋, where n = A[i][j] − Σ_{k<j} L[i][k]·L[j][k]. The numerator n is taken as 0 when the sum is at least A[i][j].
- R6: Entries are produced in the order (0,0), (1,0), (1,1), (2,0), (2,1), (2,2). Each sum uses only entries already produced.
- R7: After the last entry, done is high for exactly one cycle. The L word and err then stay unchanged while no new start is accepted.
- R8: A start pulse that arrives while a factorisation is in progress is ignored and does not change the result.
- R9: If a diagonal radicand t is zero or negative, err goes to 1 and that entry and all later entries stay zero. Done still pulses, err holds until the next accepted start, and no division by zero is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to factor the matrix on a_in |
| a_in | input | 144 | Packed input matrix, nine 16-bit slots |
| l_out | output | 216 | Packed factor L, nine 24-bit entries |
| done | output | 1 | One-cycle pulse when L is complete |
| err | output | 1 | A diagonal radicand was zero or negative |

## Verification
The hardest conditions to reach from the ports are a radicand that fails on a later row and a numerator that saturates to zero. Each needs an earlier entry whose product exactly cancels or exceeds a later element of A. The stimulus reaches them with matrices built around 65025 = 255², for which the Newton steps settle exactly on 255. This makes every intermediate L value predictable, so an element of A can be chosen to land exactly on or below the running sum. A second start is also injected partway through a run to show that it is ignored.

// File: rtl/chol_pkg.sv
package chol_pkg;
    localparam int N    = 3;
    localparam int IDXW = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACC,
        PH_ISSUE,
        PH_WAIT,
        PH_FIN
    } ph_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_WAIT
    } sq_e;
endpackage

// File: rtl/chol_div.sv
// Restoring bit-serial divider: one quotient bit per cycle, MSB first.
module chol_div #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW);
    localparam int WW = 2 * DW;

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [WW-1:0] rem;
        logic [WW-1:0] sdv;
        logic [DW-1:0] quo;
        logic          done;
        logic [DW-1:0] num;
        logic [DW-1:0] den;
    } dv_t;

    dv_t q, d;
    logic ge;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        ge     = (q.rem >= q.sdv);
        if (start && !q.busy) begin
            d.busy = 1'b1;
            d.cnt  = CW'(DW - 1);
            d.rem  = {{DW{1'b0}}, num};
            d.sdv  = {1'b0, den, {(DW-1){1'b0}}};
            d.quo  = '0;
            d.num  = num;
            d.den  = den;
        end else if (q.busy) begin
            d.quo = {q.quo[DW-2:0], ge};
            if (ge) begin
                d.rem = q.rem - q.sdv;
            end
            d.sdv = q.sdv >> 1;
            if (q.cnt == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign quo  = q.quo;

    logic [WW-1:0] chk_prod;
    assign chk_prod = {{DW{1'b0}}, q.quo} * {{DW{1'b0}}, q.den};

    // R5
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (chk_prod <= {{DW{1'b0}}, q.num}) &&
                   (({{DW{1'b0}}, q.num} - chk_prod) < {{DW{1'b0}}, q.den}));

    // R9
    div_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !q.busy) |-> (den != '0));
endmodule

// File: rtl/chol_sqrt.sv
// Newton square-root sequencer; borrows the shared divider for each step.
module chol_sqrt #(
    parameter int DW   = 24,
    parameter int ITER = 3,
    parameter int GB   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] rad,
    output logic          div_start,
    output logic [DW-1:0] div_num,
    output logic [DW-1:0] div_den,
    input  logic          div_done,
    input  logic [DW-1:0] div_quo,
    output logic          done,
    output logic [DW-1:0] root
);
    import chol_pkg::*;

    localparam int ITW = $clog2(ITER + 1);
    localparam logic [DW-1:0] SEED = DW'((1 << GB) - 1);

    typedef struct packed {
        sq_e            st;
        logic [DW-1:0]  x;
        logic [ITW-1:0] it;
        logic [DW-1:0]  rad;
        logic           done;
    } sq_t;

    sq_t q, d;
    logic [DW:0] avg;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        avg    = ({1'b0, q.x} + {1'b0, div_quo}) >> 1;
        case (q.st)
            SQ_IDLE: begin
                if (start) begin
                    d.st  = SQ_REQ;
                    d.x   = SEED;
                    d.it  = '0;
                    d.rad = rad;
                end
            end
            SQ_REQ: d.st = SQ_WAIT;
            SQ_WAIT: begin
                if (div_done) begin
                    d.x  = avg[DW-1:0];
                    d.it = q.it + 1'b1;
                    if (q.it == ITW'(ITER - 1)) begin
                        d.st   = SQ_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.st = SQ_REQ;
                    end
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign div_start = (q.st == SQ_REQ);
    assign div_num   = q.rad;
    assign div_den   = q.x;
    assign done      = q.done;
    assign root      = q.x;

    // R4
    sq_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (q.st == SQ_IDLE));

    // R9
    sq_den_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (q.x != '0));
endmodule

// File: rtl/chol3_engine.sv
module chol3_engine #(
    parameter int IW   = 16,
    parameter int DW   = 24,
    parameter int ITER = 3,
    parameter int GB   = 8
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic [chol_pkg::N*chol_pkg::N*IW-1:0]  a_in,
    output logic [chol_pkg::N*chol_pkg::N*DW-1:0]  l_out,
    output logic                                   done,
    output logic                                   err
);
    import chol_pkg::*;

    localparam int SW = 2 * DW + 2;
    localparam int NE = N * N;

    typedef struct packed {
        ph_e                             ph;
        logic [IDXW-1:0]                 i;
        logic [IDXW-1:0]                 j;
        logic [IDXW-1:0]                 k;
        logic [SW-1:0]                   sum;
        logic                            err;
        logic [N-1:0][N-1:0][DW-1:0]     a;
        logic [N-1:0][N-1:0][DW-1:0]     l;
    } st_t;

    st_t q, d;

    logic [2*DW-1:0] prod;
    logic [SW-1:0]   a_ext;
    logic [SW-1:0]   diff;
    logic            under;
    logic            diag;

    logic            ctl_div_start;
    logic [DW-1:0]   ctl_num;
    logic            sq_start;
    logic            sq_div_start;
    logic [DW-1:0]   sq_div_num;
    logic [DW-1:0]   sq_div_den;
    logic            sq_done;
    logic [DW-1:0]   sq_root;
    logic            dv_start;
    logic [DW-1:0]   dv_num;
    logic [DW-1:0]   dv_den;
    logic            dv_done;
    logic [DW-1:0]   dv_quo;

    assign prod  = q.l[q.i][q.k] * q.l[q.j][q.k];
    assign a_ext = SW'(q.a[q.i][q.j]);
    assign diff  = a_ext - q.sum;
    assign under = (q.sum >= a_ext);
    assign diag  = (q.i == q.j);

    assign ctl_num       = under ? '0 : diff[DW-1:0];
    assign ctl_div_start = (q.ph == PH_ISSUE) && !diag;
    assign sq_start      = (q.ph == PH_ISSUE) && diag && !under;

    assign dv_start = ctl_div_start | sq_div_start;
    assign dv_num   = sq_div_start ? sq_div_num : ctl_num;
    assign dv_den   = sq_div_start ? sq_div_den : q.l[q.j][q.j];

    chol_div #(.DW(DW)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .done  (dv_done),
        .quo   (dv_quo)
    );

    chol_sqrt #(.DW(DW), .ITER(ITER), .GB(GB)) u_sqrt (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sq_start),
        .rad       (diff[DW-1:0]),
        .div_start (sq_div_start),
        .div_num   (sq_div_num),
        .div_den   (sq_div_den),
        .div_done  (dv_done),
        .div_quo   (dv_quo),
        .done      (sq_done),
        .root      (sq_root)
    );

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph  = PH_ACC;
                    d.i   = '0;
                    d.j   = '0;
                    d.k   = '0;
                    d.sum = '0;
                    d.err = 1'b0;
                    d.l   = '0;
                    d.a   = '0;
                    for (int r = 0; r < N; r++) begin
                        for (int c = 0; c <= r; c++) begin
                            d.a[r][c] = {{(DW-IW){1'b0}}, a_in[IW*(N*r+c) +: IW]};
                        end
                    end
                end
            end
            PH_ACC: begin
                if (q.k == q.j) begin
                    d.ph = PH_ISSUE;
                end else begin
                    d.sum = q.sum + SW'(prod);
                    d.k   = q.k + 1'b1;
                end
            end
            PH_ISSUE: begin
                if (diag && under) begin
                    d.err = 1'b1;
                    d.ph  = PH_FIN;
                end else begin
                    d.ph = PH_WAIT;
                end
            end
            PH_WAIT: begin
                if (diag ? sq_done : dv_done) begin
                    d.l[q.i][q.j] = diag ? sq_root : dv_quo;
                    d.k   = '0;
                    d.sum = '0;
                    d.ph  = PH_ACC;
                    if (diag) begin
                        d.j = '0;
                        if (q.i == IDXW'(N - 1)) begin
                            d.ph = PH_FIN;
                        end else begin
                            d.i = q.i + 1'b1;
                        end
                    end else begin
                        d.j = q.j + 1'b1;
                    end
                end
            end
            PH_FIN: d.ph = PH_IDLE;
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        for (genvar c = 0; c < N; c++) begin : g_col
            if (c <= r) begin : g_low
                assign l_out[DW*(NE-1-(N*r+c)) +: DW] = q.l[r][c];
            end else begin : g_up
                assign l_out[DW*(NE-1-(N*r+c)) +: DW] = '0;
            end
        end
    end

    assign done = (q.ph == PH_FIN);
    assign err  = q.err;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && !start) |=> ($stable(l_out) && $stable(err)));

    // R9
    err_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (l_out[DW-1:0] == '0));

    // R6
    one_issuer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_div_start && sq_div_start));

    // R6
    sum_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_ISSUE) |-> (q.k == q.j));
endmodule

// File: tb/chol3_engine_tb.sv
module chol3_engine_tb;
    logic         clk;
    logic         rst_n;
    logic         start;
    logic [143:0] a_in;
    logic [215:0] l_out;
    logic         done;
    logic         err;

    int n_chk;
    int n_err;
    int cyc;

    logic [215:0] exp_word;
    logic         exp_err;
    bit           running;

    chol3_engine u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .a_in  (a_in),
        .l_out (l_out),
        .done  (done),
        .err   (err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [215:0] act, input logic [215:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic longint newton(input longint t);
        longint x = 255;
        for (int s = 0; s < 3; s++) x = (x + t / x) / 2;
        return x;
    endfunction

    // Behavioural reference for R2..R6, R9
    task automatic model(input logic [143:0] w);
        longint a [3][3];
        longint l [3][3];
        longint s;
        bit e = 1'b0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++) begin
                a[r][c] = longint'(w[16*(3*r+c) +: 16]);
                l[r][c] = 0;
            end
        for (int i = 0; i < 3; i++)
            for (int j = 0; j <= i; j++) begin
                if (!e) begin
                    s = 0;
                    for (int k = 0; k < j; k++) s += l[i][k] * l[j][k];
                    if (i == j) begin
                        if (s >= a[i][i]) e = 1'b1;
                        else l[i][i] = newton(a[i][i] - s);
                    end else begin
                        l[i][j] = ((s >= a[i][j]) ? 0 : a[i][j] - s) / l[j][j];
                    end
                end
            end
        exp_word = '0;
        for (int r = 0; r < 3; r++)
            for (int c = 0; c <= r; c++)
                exp_word[24*(8-(3*r+c)) +: 24] = l[r][c][23:0];
        exp_err = e;
    endtask

    function automatic logic [143:0] pack(input int a00, a10, a11, a20, a21, a22,
                                          input logic [15:0] junk);
        logic [143:0] w;
        w = '0;
        w[15:0]    = a00[15:0];
        w[31:16]   = junk;
        w[47:32]   = ~junk;
        w[63:48]   = a10[15:0];
        w[79:64]   = a11[15:0];
        w[95:80]   = junk ^ 16'h5a5a;
        w[111:96]  = a20[15:0];
        w[127:112] = a21[15:0];
        w[143:128] = a22[15:0];
        return w;
    endfunction

    // Every-cycle comparison against the reference (R3, R4, R5, R7, R9)
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            if (done) begin
                chk(running, "R7 done without run", 216'(done), 216'(0));
                chk(l_out == exp_word, "R4/R5/R6 result", l_out, exp_word);
                chk(err == exp_err, "R9 err flag", 216'(err), 216'(exp_err));
                running = 1'b0;
            end else if (!running) begin
                chk(l_out == exp_word, "R7 hold word", l_out, exp_word);
                chk(err == exp_err, "R7 hold err", 216'(err), 216'(exp_err));
            end
        end
    end

    task automatic run(input logic [143:0] w, input bit intr, input logic [143:0] w2);
        int t;
        @(negedge clk);
        running = 1'b1;
        model(w);
        a_in  = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (intr) begin
            // R8: extra starts mid-run must be ignored
            repeat (30) @(negedge clk);
            a_in = w2; start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (80) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (running && t < 4000) begin
            @(posedge clk);
            t++;
        end
        if (running) begin
            chk(1'b0, "R7 watchdog", 216'(0), 216'(1));
            running = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_err++;
                $display("FAIL R7 global watchdog actual=%0d expected<150000", cyc);
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        end
    end

    initial begin
        n_chk = 0; n_err = 0;
        running = 1'b0;
        exp_word = '0; exp_err = 1'b0;
        start = 1'b0; a_in = '0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(l_out == '0, "R1 reset word", l_out, '0);
        chk(done == 1'b0 && err == 1'b0, "R1 reset flags", 216'({done, err}), 216'(0));
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 exact seed case: 255^2 settles on 255; R5 plain divides
        run(pack(65025, 2550, 65125, 1275, 5100, 1000, 16'h0000), 1'b0, '0);
        // R2 same matrix, upper slots full of junk
        run(pack(65025, 2550, 65125, 1275, 5100, 1000, 16'hffff), 1'b0, '0);
        // R8 mid-run start ignored
        run(pack(40000, 3000, 9000, 2000, 1500, 7000, 16'h1234), 1'b1,
            pack(100, 1, 100, 1, 1, 100, 16'h0));
        // R5 numerator saturates to zero (L21 sum exceeds A21 = 0)
        run(pack(65025, 2550, 65025, 2550, 0, 65025, 16'h0f0f), 1'b0, '0);
        // R9 error at the first diagonal
        run(pack(0, 10, 10, 10, 10, 10, 16'h0), 1'b0, '0);
        // R9 error at row 1: radicand exactly zero
        run(pack(65025, 2550, 100, 20, 20, 500, 16'hbeef), 1'b0, '0);
        // R9 error at row 2: radicand negative
        run(pack(65025, 0, 65025, 2550, 2550, 150, 16'h0), 1'b0, '0);
        // R4 small radicands with poor convergence
        run(pack(1, 0, 4, 0, 0, 9, 16'h0), 1'b0, '0);
        // R4/R5 near full-scale elements
        run(pack(65535, 65535, 65535, 65535, 65535, 65535, 16'h0), 1'b0, '0);

        // R6 random positive-definite matrices built as L*L^T
        for (int n = 0; n < 20; n++) begin
            int l00 = 1 + int'($urandom_range(249));
            int l10 = int'($urandom_range(60));
            int l11 = 1 + int'($urandom_range(149));
            int l20 = int'($urandom_range(60));
            int l21 = int'($urandom_range(60));
            int l22 = 1 + int'($urandom_range(149));
            run(pack(l00*l00, l10*l00, l10*l10 + l11*l11, l20*l00,
                     l20*l10 + l21*l11, l20*l20 + l21*l21 + l22*l22,
                     16'($urandom)), 1'b0, '0);
        end

        // R1 asynchronous reset during a run
        @(negedge clk);
        running = 1'b1;
        a_in = pack(40000, 3000, 9000, 2000, 1500, 7000, 16'h0);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        running = 1'b0; exp_word = '0; exp_err = 1'b0;
        #2;
        chk(l_out == '0, "R1 mid-run reset word", l_out, '0);
        chk(done == 1'b0 && err == 1'b0, "R1 mid-run reset flags", 216'({done, err}), 216'(0));
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule